// File: doc/BRIEF.md
# SPI Mode-3 Framed Transaction Master

This block is a synchronous serial master that runs one complete framed transaction at a time against a single slave. A frame is always 64 serial clock cycles long. It carries an 8-bit command and a 24-bit address, then a 32-bit data phase. The data phase is either driven out on MOSI (write) or captured from MISO (read), and the host chooses which with a per-request read flag.

The host pulses `start` while `busy` is low. The block copies the request into its shift register on that cycle, so the request inputs may change afterwards. It lowers the chip select, clocks the frame out in SPI mode 3 (clock idles high, MOSI changes on falling edges, MISO is sampled on rising edges) and raises the chip select again. In that same cycle it pulses `done` and, for a read, presents the captured word on `rdata`. The serial clock runs at the system clock divided by `2*HALF_DIV`.

Top module: `spi_txn_master`

## Requirements
- R1: After reset and between transactions, cs_n is 1, sclk is 1, mosi is 0, and busy and done are 0. rdata resets to 0.
- R2: A start pulse is accepted only while busy is 0. A start pulse while busy is 1 is ignored: the running frame is unchanged and no extra transaction follows.
- R3: cs_n goes low in the cycle after an accepted start. The first falling sclk edge comes HALF_DIV system cycles after that, and every sclk level lasts exactly HALF_DIV system cycles.
- R4: Each transaction has exactly 64 falling and 64 rising sclk edges. sclk ends high, and cs_n rises HALF_DIV system cycles after the 64th rising edge.
- R5: While cs_n is low, mosi changes only in the cycle of a falling sclk edge. The 64 bits seen at the rising edges are cmd[7:0], then addr[23:0], then the data phase, each field MSB first.
- R6: In a write (rd=0), the data phase on mosi is wdata[31:0], MSB first.
- R7: In a read (rd=1), mosi is 0 for the whole data phase. The MISO bits sampled at rising edges 33 to 64 form rdata, with the first of them as bit 31. rdata holds that value from the cycle done pulses.
- R8: In a write, MISO is ignored and rdata keeps the value it had before the transaction.
- R9: done is high for exactly one system cycle, the cycle in which cs_n returns high. busy is high from the cycle cs_n falls through that cycle, and low in the cycle after.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Request pulse, taken only while idle |
| rd | input | 1 | 1 = read data phase, 0 = write data phase |
| cmd | input | 8 | Command byte |
| addr | input | 24 | Address field |
| wdata | input | 32 | Write data |
| busy | output | 1 | Transaction in progress |
| done | output | 1 | One-cycle end-of-transaction pulse |
| rdata | output | 32 | Word captured in the last read |
| sclk | output | 1 | Serial clock, idles high |
| cs_n | output | 1 | Active-low chip select |
| mosi | output | 1 | Serial data out |
| miso | input | 1 | Serial data in |

## Verification
The hardest case to reach from the ports is a start request that arrives in the middle of a running frame and carries different fields. The stimulus raises start partway through a frame, with the request inputs flipped. It also changes the inputs right after every accepted start. The expected frame and the quiet chip select after done then show that neither event reached the shifter. For writes, the slave model drives random MISO bits to show that rdata does not move.

// File: rtl/spi_txn_pkg.sv
// Shared widths and state type for the framed SPI master.
// Assumes a fixed 8 + 24 + 32 bit frame layout.
package spi_txn_pkg;
    localparam int CMD_W   = 8;
    localparam int ADDR_W  = 24;
    localparam int DATA_W  = 32;
    localparam int FRAME_W = CMD_W + ADDR_W + DATA_W;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_RUN  = 2'd1,
        ST_END  = 2'd2
    } txn_state_t;
endpackage

// File: rtl/spi_half_tick.sv
// Half-period tick generator: pulses once every HALF_DIV system cycles while enabled.
// Assumes HALF_DIV >= 1. The count restarts from zero whenever en drops.
module spi_half_tick #(
    parameter int HALF_DIV = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic en,
    output logic tick
);
    localparam int CW = $clog2(HALF_DIV + 1);

    logic [CW-1:0] cnt;

    assign tick = en && (cnt == CW'(HALF_DIV - 1));

    // Count system cycles inside the current half period.
    always_ff @(posedge clk) begin
        if (!rst_n || !en) begin
            cnt <= '0;
        end else if (tick) begin
            cnt <= '0;
        end else begin
            cnt <= cnt + 1'b1;
        end
    end
endmodule

// File: rtl/spi_bit_engine.sv
// Serial bit engine: on each tick it toggles sclk. A falling edge shifts the next
// frame bit onto mosi (MSB first); a rising edge samples miso. 'finish' flags the
// tick that follows the last rising edge.
// Assumes load is only raised while no frame is in flight.
module spi_bit_engine
    import spi_txn_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               load,
    input  logic [FRAME_W-1:0] frame,
    input  logic               tick,
    input  logic               miso,
    output logic               sclk,
    output logic               mosi,
    output logic [DATA_W-1:0]  rx_word,
    output logic               finish
);
    localparam int EDGES = 2 * FRAME_W;
    localparam int EW    = $clog2(EDGES + 1);

    logic [FRAME_W-1:0] tx_sr;
    logic [EW-1:0]      eidx;

    assign finish = tick && (eidx == EW'(EDGES));

    // Edge sequencing, output shifting and input sampling.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tx_sr   <= '0;
            eidx    <= '0;
            sclk    <= 1'b1;
            mosi    <= 1'b0;
            rx_word <= '0;
        end else if (load) begin
            tx_sr <= frame;
            eidx  <= '0;
            sclk  <= 1'b1;
            mosi  <= 1'b0;
        end else if (finish) begin
            mosi <= 1'b0;
        end else if (tick) begin
            if (!eidx[0]) begin
                sclk  <= 1'b0;
                mosi  <= tx_sr[FRAME_W-1];
                tx_sr <= {tx_sr[FRAME_W-2:0], 1'b0};
            end else begin
                sclk    <= 1'b1;
                rx_word <= {rx_word[DATA_W-2:0], miso};
            end
            eidx <= eidx + 1'b1;
        end
    end
endmodule

// File: rtl/spi_txn_master.sv
// Mode-3 SPI transaction master. It frames one command/address/data transfer per
// accepted start, decides per request whether the data phase is sent or captured,
// and reports completion with a single-cycle done pulse.
// Assumes one slave, HALF_DIV >= 1, and the request fields valid with start.
module spi_txn_master
    import spi_txn_pkg::*;
#(
    parameter int HALF_DIV = 2
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        start,
    input  logic        rd,
    input  logic [7:0]  cmd,
    input  logic [23:0] addr,
    input  logic [31:0] wdata,
    output logic        busy,
    output logic        done,
    output logic [31:0] rdata,
    output logic        sclk,
    output logic        cs_n,
    output logic        mosi,
    input  logic        miso
);
    txn_state_t         state;
    logic               is_rd;
    logic               load;
    logic               tick;
    logic               finish;
    logic [FRAME_W-1:0] frame;
    logic [DATA_W-1:0]  rx_word;

    assign load  = (state == ST_IDLE) && start;
    assign frame = {cmd, addr, (rd ? {DATA_W{1'b0}} : wdata)};
    assign busy  = (state != ST_IDLE);
    assign done  = (state == ST_END);

    spi_half_tick #(.HALF_DIV(HALF_DIV)) u_tick (
        .clk   (clk),
        .rst_n (rst_n),
        .en    (state == ST_RUN),
        .tick  (tick)
    );

    spi_bit_engine u_engine (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (load),
        .frame   (frame),
        .tick    (tick),
        .miso    (miso),
        .sclk    (sclk),
        .mosi    (mosi),
        .rx_word (rx_word),
        .finish  (finish)
    );

    // Transaction sequencing, chip-select framing and read-data capture.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= ST_IDLE;
            cs_n  <= 1'b1;
            is_rd <= 1'b0;
            rdata <= '0;
        end else begin
            case (state)
                ST_IDLE: if (start) begin
                    state <= ST_RUN;
                    cs_n  <= 1'b0;
                    is_rd <= rd;
                end
                ST_RUN: if (finish) begin
                    state <= ST_END;
                    cs_n  <= 1'b1;
                    if (is_rd) rdata <= rx_word;
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    // R1: an idle block keeps the bus quiet.
    assert_idle_bus_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (cs_n && sclk && !mosi));

    // R2: a start seen mid-frame leaves the latched direction alone.
    assert_busy_start_ignored_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_RUN && start) |=> $stable(is_rd));

    // R4: the serial clock is high whenever chip select is released.
    assert_sclk_high_at_release_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cs_n) |-> sclk);

    // R5: inside a frame, mosi only moves together with a falling sclk.
    assert_mosi_on_fall_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (!cs_n && $past(!cs_n) && !$fell(sclk)) |-> $stable(mosi));

    // R8: a write frame never touches the read-data register.
    assert_write_keeps_rdata_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_RUN && !is_rd) |=> $stable(rdata));

    // R9: done marks the release of chip select and lasts one cycle.
    assert_done_at_release_R9: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> $rose(cs_n));
    assert_done_single_R9: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> (!done && !busy));
endmodule

// File: tb/tb_spi_txn_master.sv
// Bench: directed corner frames and seeded random frames against a bench-side slave model.
module tb_spi_txn_master;
    localparam int HD = 3;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic        rd = 1'b0;
    logic [7:0]  cmd = '0;
    logic [23:0] addr = '0;
    logic [31:0] wdata = '0;
    logic        miso = 1'b0;
    logic        busy, done, sclk, cs_n, mosi;
    logic [31:0] rdata;

    int n_cmp = 0;
    int n_bad = 0;

    always #5 clk = ~clk;

    spi_txn_master #(.HALF_DIV(HD)) dut (
        .clk(clk), .rst_n(rst_n), .start(start), .rd(rd), .cmd(cmd), .addr(addr),
        .wdata(wdata), .busy(busy), .done(done), .rdata(rdata), .sclk(sclk),
        .cs_n(cs_n), .mosi(mosi), .miso(miso)
    );

    task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [63:0] exp_frame(input bit r, input logic [7:0] c,
                                              input logic [23:0] a, input logic [31:0] w);
        return {c, a, (r ? 32'h0 : w)};
    endfunction

    // One full transaction with a MISO-driving, MOSI-capturing slave model.
    task automatic txn(input bit r, input logic [7:0] c, input logic [23:0] a,
                       input logic [31:0] w, input logic [31:0] sw, input bit poke);
        logic [63:0] seen = '0;
        logic [31:0] old_rd;
        int falls = 0, rises = 0, cyc = 0, last_edge = 0;
        bit gap_ok = 1, mosi_ok = 1;
        logic prev_sclk, prev_mosi;
        @(negedge clk);
        old_rd = rdata;
        chk(!busy, "R2 idle before start", {63'd0, busy}, 64'd0);
        rd = r; cmd = c; addr = a; wdata = w; start = 1'b1;
        @(negedge clk);
        start = 1'b0; rd = ~r; cmd = ~c; addr = ~a; wdata = ~w;
        chk(cs_n == 1'b0 && busy, "R3 cs_n low one cycle after start", {62'd0, cs_n, busy}, 64'd1);
        prev_sclk = sclk; prev_mosi = mosi;
        while (!done && cyc < 2000) begin
            @(negedge clk);
            cyc++;
            if (poke && cyc == 20) start = 1'b1;
            if (poke && cyc == 21) start = 1'b0;
            if (prev_sclk && !sclk) begin
                falls++;
                if (falls == 1) chk(cyc == HD, "R3 first falling edge delay", 64'(cyc), 64'(HD));
                else if (cyc - last_edge != HD) gap_ok = 0;
                last_edge = cyc;
                miso = (r && falls > 32) ? sw[64 - falls] : 1'($urandom);
            end else if (!prev_sclk && sclk) begin
                rises++;
                seen = {seen[62:0], mosi};
                if (cyc - last_edge != HD) gap_ok = 0;
                last_edge = cyc;
            end else if (!cs_n && mosi !== prev_mosi) begin
                mosi_ok = 0;
            end
            prev_sclk = sclk; prev_mosi = mosi;
        end
        chk(done && cs_n && busy, "R9 done with cs_n release and busy", {61'd0, done, cs_n, busy}, 64'd7);
        chk(falls == 64 && rises == 64, "R4 edge counts", {32'(falls), 32'(rises)}, {32'd64, 32'd64});
        chk(cyc - last_edge == HD && sclk, "R4 release gap and sclk high", 64'(cyc - last_edge), 64'(HD));
        chk(gap_ok, "R3 sclk level widths", {63'd0, gap_ok}, 64'd1);
        chk(mosi_ok, "R5 mosi moves only on falling edge", {63'd0, mosi_ok}, 64'd1);
        chk(seen == exp_frame(r, c, a, w), r ? "R7 read frame on mosi" : "R6 R5 write frame on mosi",
            seen, exp_frame(r, c, a, w));
        if (r) chk(rdata == sw, "R7 captured read data", 64'(rdata), 64'(sw));
        else   chk(rdata == old_rd, "R8 write leaves rdata", 64'(rdata), 64'(old_rd));
        @(negedge clk);
        chk(!busy && !done && cs_n, "R9 busy low after release", {62'd0, busy, done}, 64'd0);
        if (poke) begin
            repeat (2 * HD + 2) @(negedge clk);
            chk(cs_n && !busy, "R2 mid-frame start ignored", {62'd0, cs_n, busy}, 64'd2);
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_cmp++; n_bad++;
        $display("FAIL R1 watchdog expired actual=running expected=finished");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        int unsigned seed;
        seed = $urandom(32'd2024);
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(cs_n && sclk && !mosi && !busy && !done, "R1 idle after reset",
            {59'd0, cs_n, sclk, mosi, busy, done}, {59'd0, 5'b11000});
        chk(rdata == 32'h0, "R1 rdata reset", 64'(rdata), 64'd0);
        // Directed corners.
        txn(1'b0, 8'h02, 24'hFFFFFF, 32'hFFFF_FFFF, 32'h0, 1'b0);
        txn(1'b1, 8'h05, 24'h000001, 32'hDEAD_BEEF, 32'hA5A5_5A5A, 1'b0);
        txn(1'b0, 8'h80, 24'h800000, 32'h0000_0001, 32'h0, 1'b1);
        txn(1'b1, 8'hFF, 24'h123456, 32'h0, 32'h8000_0001, 1'b1);
        chk(cs_n && sclk && !mosi, "R1 idle between transactions",
            {61'd0, cs_n, sclk, mosi}, {61'd0, 3'b110});
        // Seeded random frames.
        for (int i = 0; i < 12; i++) begin
            txn(1'($urandom), 8'($urandom), 24'($urandom), $urandom, $urandom, (i % 4) == 1);
        end
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule